// File: doc/BRIEF.md
# DRAM Strobe Sequencer

This block drives the active-low row and column strobes of a DRAM for two cycle types: an ordinary read or write access, and a CAS-before-RAS refresh. Every phase has its own small length code, so slow or fast parts can be matched without changing the logic. An access opens the row, then strobes the column, then precharges. A refresh waits a short delay, drops CAS, then holds RAS low for a programmable pulse, then precharges.

A requester raises a one-cycle access or refresh pulse. The block starts at once if idle, or remembers the request if busy. It reports activity on `busy` and marks the end of each cycle with a one-cycle `done`. The length codes are captured when a cycle starts, so software may rewrite them at any time.

Top module: `dram_strobe_seq`

## Requirements
- R1: Out of reset and whenever idle: `ras_n`=1, `cas_n`=1, `row_sel`=1, `we_n`=1, `busy`=0, `done`=0.
- R2: An access starts on the edge after the request. The row phase then lasts `cfg_ras_len`+1 cycles (code 0..3 gives 1..4), with `ras_n`=0, `cas_n`=1 and `row_sel`=1.
- R3: The column phase follows and lasts `cfg_cas_len`+1 cycles, with `ras_n`=0, `cas_n`=0 and `row_sel`=0. During this phase `we_n` is 0 if the request carried `acc_wr`=1, and 1 otherwise.
- R4: Precharge follows an access and lasts `cfg_pre_len`+1 cycles with both strobes high. After it comes exactly one cycle with `done`=1 and `busy`=0.
- R5: A refresh starts with both strobes high for 1 cycle when `cfg_ref_dly`=0, or for 2 cycles when it is 1.
- R6: In a refresh, `cas_n` falls one cycle before `ras_n`. During that one cycle `ras_n` is still 1.
- R7: In a refresh, both strobes stay low for `cfg_ref_pw`+2 cycles (code 0..3 gives 2..5). Then comes a precharge of `cfg_pre_len`+1 cycles and a one-cycle `done`.
- R8: If both requests arrive in the same cycle, the refresh runs first and the access runs right after it.
- R9: A request that arrives while busy is kept and runs after the current cycle's `done`.
- R10: The length codes and the write flag are captured at the start of a cycle. Changing them mid-cycle does not affect that cycle.
- R11: `busy` is 1 in every cycle from the first phase through the last precharge cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | Access request pulse |
| acc_wr | input | 1 | Write flag of the access request |
| ref_req | input | 1 | Refresh request pulse |
| cfg_ras_len | input | 2 | Row phase length code |
| cfg_cas_len | input | 2 | Column phase length code |
| cfg_pre_len | input | 2 | Precharge length code |
| cfg_ref_pw | input | 2 | Refresh RAS pulse length code |
| cfg_ref_dly | input | 1 | Refresh delay before CAS falls |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_sel | output | 1 | 1 selects the row address, 0 the column address |
| we_n | output | 1 | Write enable, active low, during the access column phase |
| busy | output | 1 | A cycle is in progress |
| done | output | 1 | One-cycle end-of-cycle pulse |

## Verification
The access path is swept over every combination of row, column and precharge codes, for both reads and writes. Each cycle of the strobe waveform is compared with a sequence built from the codes by arithmetic, so a wrong phase length shows up as a shifted edge. The refresh path is swept over every delay, pulse and precharge code; this separates the refresh delay and refresh pulse counts from the access counts. Directed patterns cover three cases: simultaneous requests (priority order), a request arriving mid-cycle (it must be held), and codes rewritten during a cycle (they must have been captured at the start).

// File: rtl/dram_strobe_seq.sv
module dram_strobe_seq #(
  parameter int FW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_req,
  input  logic          acc_wr,
  input  logic          ref_req,
  input  logic [FW-1:0] cfg_ras_len,
  input  logic [FW-1:0] cfg_cas_len,
  input  logic [FW-1:0] cfg_pre_len,
  input  logic [FW-1:0] cfg_ref_pw,
  input  logic          cfg_ref_dly,
  output logic          ras_n,
  output logic          cas_n,
  output logic          row_sel,
  output logic          we_n,
  output logic          busy,
  output logic          done
);
  localparam int CW = FW + 1;

  typedef enum logic [2:0] {
    S_IDLE, S_ROW, S_COL, S_APRE, S_RWAIT, S_RCAS, S_RRAS, S_RPRE
  } st_t;

  st_t st, nst;
  logic [CW-1:0] cnt, ncnt;
  logic [FW-1:0] k_cas, k_pre, k_rpw;
  logic k_wr, pend_acc, pend_ref, pend_wr;

  wire ref_go  = ref_req | pend_ref;
  wire acc_go  = acc_req | pend_acc;
  wire idle    = (st == S_IDLE);
  wire ref_gnt = idle & ref_go;
  wire acc_gnt = idle & ~ref_go & acc_go;
  wire last    = (cnt == '0);

  assign busy = ~idle;

  always_comb begin
    nst  = st;
    ncnt = last ? cnt : cnt - 1'b1;
    case (st)
      S_IDLE: begin
        ncnt = '0;
        if (ref_go) begin
          nst  = S_RWAIT;
          ncnt = {{(CW-1){1'b0}}, cfg_ref_dly};
        end else if (acc_go) begin
          nst  = S_ROW;
          ncnt = {1'b0, cfg_ras_len};
        end
      end
      S_ROW:   if (last) begin nst = S_COL;  ncnt = {1'b0, k_cas}; end
      S_COL:   if (last) begin nst = S_APRE; ncnt = {1'b0, k_pre}; end
      S_APRE:  if (last) nst = S_IDLE;
      S_RWAIT: if (last) begin nst = S_RCAS; ncnt = '0; end
      S_RCAS:  begin nst = S_RRAS; ncnt = {1'b0, k_rpw} + 1'b1; end
      S_RRAS:  if (last) begin nst = S_RPRE; ncnt = {1'b0, k_pre}; end
      S_RPRE:  if (last) nst = S_IDLE;
      default: nst = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      k_cas    <= '0;
      k_pre    <= '0;
      k_rpw    <= '0;
      k_wr     <= 1'b0;
      pend_acc <= 1'b0;
      pend_ref <= 1'b0;
      pend_wr  <= 1'b0;
    end else begin
      st       <= nst;
      cnt      <= ncnt;
      pend_ref <= (pend_ref | ref_req) & ~ref_gnt;
      pend_acc <= (pend_acc | acc_req) & ~acc_gnt;
      if (acc_req) pend_wr <= acc_wr;
      if (ref_gnt | acc_gnt) begin
        k_cas <= cfg_cas_len;
        k_pre <= cfg_pre_len;
        k_rpw <= cfg_ref_pw;
      end
      if (acc_gnt) k_wr <= acc_req ? acc_wr : pend_wr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_n   <= 1'b1;
      cas_n   <= 1'b1;
      row_sel <= 1'b1;
      we_n    <= 1'b1;
      done    <= 1'b0;
    end else begin
      ras_n   <= ~(nst == S_ROW || nst == S_COL || nst == S_RRAS);
      cas_n   <= ~(nst == S_COL || nst == S_RCAS || nst == S_RRAS);
      row_sel <= (nst != S_COL);
      we_n    <= ~((nst == S_COL) && (st == S_COL || st == S_ROW) && k_wr);
      done    <= (st == S_APRE || st == S_RPRE) && last;
    end
  end
endmodule

module dram_strobe_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic row_sel,
  input logic we_n,
  input logic busy,
  input logic done
);
  p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n && row_sel && we_n));
  p_col_strobes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !row_sel |-> (!ras_n && !cas_n));
  p_we_in_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> !row_sel);
  p_done_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && ras_n && cas_n));
  p_cas_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && ras_n) |=> !ras_n);
  p_busy_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
endmodule

bind dram_strobe_seq dram_strobe_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n),
  .row_sel(row_sel), .we_n(we_n), .busy(busy), .done(done)
);

// File: tb/dram_strobe_seq_tb.sv
module dram_strobe_seq_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic acc_req = 1'b0, acc_wr = 1'b0, ref_req = 1'b0, cfg_ref_dly = 1'b0;
  logic [1:0] cfg_ras_len = '0, cfg_cas_len = '0, cfg_pre_len = '0, cfg_ref_pw = '0;
  logic ras_n, cas_n, row_sel, we_n, busy, done;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  dram_strobe_seq u_dut (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_wr(acc_wr), .ref_req(ref_req),
    .cfg_ras_len(cfg_ras_len), .cfg_cas_len(cfg_cas_len), .cfg_pre_len(cfg_pre_len),
    .cfg_ref_pw(cfg_ref_pw), .cfg_ref_dly(cfg_ref_dly),
    .ras_n(ras_n), .cas_n(cas_n), .row_sel(row_sel), .we_n(we_n), .busy(busy), .done(done)
  );

  // vector order {ras_n, cas_n, row_sel, we_n, busy, done}; busy bit covers R11
  task automatic check(string tag, logic [5:0] exp);
    logic [5:0] act = {ras_n, cas_n, row_sel, we_n, busy, done};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // called at the negedge where the first phase is visible; returns at the negedge after done
  task automatic expect_seq(string pre_tag, bit is_ref, int ra, int ca, int pr,
                            int pw, int dl, bit wr);
    int n1, n2, n3, n4, tot;
    if (is_ref) begin n1 = dl + 1; n2 = 1; n3 = pw + 2; end
    else        begin n1 = ra + 1; n2 = ca + 1; n3 = 0; end
    n4 = pr + 1;
    tot = n1 + n2 + n3 + n4;
    for (int i = 0; i <= tot; i++) begin
      logic [5:0] e;
      string t;
      if (i == tot) begin e = 6'b111101; t = is_ref ? "R7" : "R4"; end
      else if (i < n1) begin
        e = is_ref ? 6'b111110 : 6'b011110; t = is_ref ? "R5" : "R2";
      end else if (i < n1 + n2) begin
        e = is_ref ? 6'b101110 : {3'b000, ~wr, 2'b10}; t = is_ref ? "R6" : "R3";
      end else if (i < n1 + n2 + n3) begin e = 6'b001110; t = "R7"; end
      else begin e = 6'b111110; t = is_ref ? "R7" : "R4"; end
      check({pre_tag, t}, e);
      @(negedge clk);
    end
  endtask

  task automatic pulse_acc(bit wr);
    acc_req = 1'b1; acc_wr = wr;
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  task automatic pulse_ref();
    ref_req = 1'b1;
    @(negedge clk);
    ref_req = 1'b0;
  endtask

  task automatic set_cfg(int ra, int ca, int pr, int pw, int dl);
    cfg_ras_len = 2'(ra); cfg_cas_len = 2'(ca); cfg_pre_len = 2'(pr);
    cfg_ref_pw = 2'(pw); cfg_ref_dly = 1'(dl);
  endtask

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 6'b111100);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle", 6'b111100);

    // access sweep: R2 R3 R4
    for (int ra = 0; ra < 4; ra++)
      for (int ca = 0; ca < 4; ca++)
        for (int pr = 0; pr < 4; pr++)
          for (int wr = 0; wr < 2; wr++) begin
            set_cfg(ra, ca, pr, 0, 0);
            pulse_acc(wr[0]);
            expect_seq("", 1'b0, ra, ca, pr, 0, 0, wr[0]);
            check("R1 back idle", 6'b111100);
          end

    // refresh sweep: R5 R6 R7
    for (int dl = 0; dl < 2; dl++)
      for (int pw = 0; pw < 4; pw++)
        for (int pr = 0; pr < 4; pr++) begin
          set_cfg(3, 3, pr, pw, dl);
          pulse_ref();
          expect_seq("", 1'b1, 3, 3, pr, pw, dl, 1'b0);
        end

    // R8: simultaneous requests, refresh first then access
    set_cfg(1, 2, 1, 1, 1);
    acc_req = 1'b1; acc_wr = 1'b1; ref_req = 1'b1;
    @(negedge clk);
    acc_req = 1'b0; ref_req = 1'b0;
    expect_seq("R8 ", 1'b1, 1, 2, 1, 1, 1, 1'b0);
    expect_seq("R8 ", 1'b0, 1, 2, 1, 1, 1, 1'b1);
    check("R8 idle", 6'b111100);

    // R9: refresh arriving during an access is held
    set_cfg(2, 1, 0, 2, 0);
    pulse_acc(1'b0);
    fork
      expect_seq("R9 ", 1'b0, 2, 1, 0, 2, 0, 1'b0);
      begin @(negedge clk); @(negedge clk); pulse_ref(); end
    join
    expect_seq("R9 ", 1'b1, 2, 1, 0, 2, 0, 1'b0);
    check("R9 idle", 6'b111100);

    // R10: codes and write flag changed mid-cycle do not affect the running cycle
    set_cfg(1, 1, 1, 0, 0);
    pulse_acc(1'b1);
    fork
      expect_seq("R10 ", 1'b0, 1, 1, 1, 0, 0, 1'b1);
      begin @(negedge clk); set_cfg(3, 3, 3, 3, 1); acc_wr = 1'b0; end
    join
    set_cfg(0, 0, 2, 0, 1);
    pulse_ref();
    fork
      expect_seq("R10 ", 1'b1, 0, 0, 2, 0, 1, 1'b0);
      begin @(negedge clk); set_cfg(3, 3, 0, 3, 0); end
    join
    check("R10 idle", 6'b111100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule